// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Software sets each pin's direction, drive enable and output level through a 32-bit register port. It reads back the synchronized pin inputs. Any pin can be released to an alternate function. Every pin can raise an interrupt on a level (high or low) or on an edge (rising, falling or both). Interrupts latch in a status word. A read of that word returns the latched bits and clears them in the same access.

A per-pin mask gates the status bits into a single registered interrupt line. Two write-one ports change the mask: one unmasks the pins whose bits are written as 1, and the other masks them. Software reads the status word, takes status AND NOT mask as its pending sources, and serves them. A level condition that is still present sets its bit again right away, so software sees it on the next read.

Byte offsets (address bits [5:2] select the word):

| Offset | Word |
|---|---|
| 0x00 | bypass |
| 0x04 | direction |
| 0x08 | drive enable |
| 0x0C | output level |
| 0x10 | input |
| 0x14 | mask (read-only) |
| 0x18 | unmask (write-one) |
| 0x1C | mask set (write-one) |
| 0x20 | status (clear on read) |
| 0x24 | sense type |
| 0x28 | polarity |
| 0x2C | both-edges |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction word (0x04) and the mask word (0x14) read as all ones over the implemented pins, the status word (0x20) reads 0, and both `irq` and `pad_oe` are 0.
- R2: A pin is driven (`pad_oe` bit 1) only when three conditions hold together: its drive-enable bit (0x08) is 1, its direction bit (0x04) is 0, and its bypass bit (0x00) is 0. A direction bit of 1 makes the pin an input. `pad_out` follows the output level word (0x0C).
- R3: A bypass bit of 1 (0x00) sets that pin's `alt_sel` bit and stops the controller from driving the pin. A bypass bit of 0 keeps the pin under the controller.
- R4: The input word (0x10) returns `pad_in` after a two-flop synchronizer, so a pin change is visible two clock edges later.
- R5: Writing 1s to the unmask word (0x18) clears those bits of the mask word. Bits written as 0 keep their value.
- R6: Writing 1s to the mask-set word (0x1C) sets those bits of the mask word. Bits written as 0 keep their value.
- R7: With sense type 1 (0x24), a pin sets its status bit on every cycle in which its synchronized input equals its polarity bit (0x28): 1 means high, 0 means low.
- R8: With sense type 0, a pin sets its status bit when its synchronized input differs from the previous sample in the chosen direction: rising if polarity is 1, falling if it is 0. If its both-edges bit (0x2C) is 1, any change sets the bit and the polarity bit is ignored.
- R9: A read of the status word returns every latched bit and clears all of them in the same cycle. Without such a read, a set status bit stays set.
- R10: If a sense condition occurs in the same cycle as a clearing read, its status bit is set again after that read, so the event is kept.
- R11: `irq` is a register that goes to 1 one cycle after any pin has status 1 and mask 0, and is 0 otherwise.
- R12: Pins at or above `NPINS` read as 0 in every word and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; a read of the status word clears it |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| pad_in | input | 32 | Pin inputs, asynchronous |
| pad_out | output | 32 | Output level per pin |
| pad_oe | output | 32 | Drive enable per pin |
| alt_sel | output | 32 | Pin handed to the alternate function |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge whose detection lands on exactly the same clock edge as a clearing status read. The synchronizer delay has to be counted edge by edge so that the read strobe covers the cycle in which the detector fires. The bench changes a pin, waits two rising edges, and issues the read in the following cycle. It then expects that read to return 0 for the pin and the next read to return 1. A still-true level source is checked the same way, by reading twice in a row and expecting the bit both times.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe,
  output logic [31:0] alt_sel,
  output logic        irq
);
  localparam logic [31:0] PMASK = 32'hFFFF_FFFF >> (32 - NPINS);

  logic [31:0] byp_q, dir_q, oe_q, out_q, msk_q, st_q, typ_q, pol_q, both_q;
  logic [31:0] s1_q, s2_q, s3_q;
  logic [31:0] wd, lvl_hit, edg_hit, hit;
  logic [3:0]  widx;
  logic        rd_clr, irq_q;

  assign widx    = reg_addr[5:2];
  assign wd      = reg_wdata & PMASK;
  assign rd_clr  = reg_rd && (widx == 4'h8);
  assign lvl_hit = ~(s2_q ^ pol_q);
  assign edg_hit = both_q & (s2_q ^ s3_q)
                 | ~both_q & ((s2_q & ~s3_q & pol_q) | (~s2_q & s3_q & ~pol_q));
  assign hit     = ((typ_q & lvl_hit) | (~typ_q & edg_hit)) & PMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q  <= '0;
      dir_q  <= PMASK;
      oe_q   <= '0;
      out_q  <= '0;
      msk_q  <= PMASK;
      st_q   <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
      both_q <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      s1_q  <= pad_in & PMASK;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      st_q  <= (rd_clr ? 32'h0 : st_q) | hit;
      irq_q <= |(st_q & ~msk_q);
      if (reg_wr) begin
        case (widx)
          4'h0: byp_q  <= wd;
          4'h1: dir_q  <= wd;
          4'h2: oe_q   <= wd;
          4'h3: out_q  <= wd;
          4'h6: msk_q  <= msk_q & ~wd;
          4'h7: msk_q  <= msk_q | wd;
          4'h9: typ_q  <= wd;
          4'hA: pol_q  <= wd;
          4'hB: both_q <= wd;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (widx)
      4'h0:    reg_rdata = byp_q;
      4'h1:    reg_rdata = dir_q;
      4'h2:    reg_rdata = oe_q;
      4'h3:    reg_rdata = out_q;
      4'h4:    reg_rdata = s2_q;
      4'h5:    reg_rdata = msk_q;
      4'h8:    reg_rdata = st_q;
      4'h9:    reg_rdata = typ_q;
      4'hA:    reg_rdata = pol_q;
      4'hB:    reg_rdata = both_q;
      default: reg_rdata = '0;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = oe_q & ~dir_q & ~byp_q;
  assign alt_sel = byp_q;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPINS = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  reg_addr,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        reg_rd,
  input logic [31:0] reg_rdata,
  input logic [31:0] pad_oe,
  input logic        irq,
  input logic [31:0] msk_q,
  input logic [31:0] st_q
);
  localparam logic [31:0] PM = 32'hFFFF_FFFF >> (32 - NPINS);

  p_all_inputs_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[5:2] == 4'h1 && (reg_wdata & PM) == PM) |=> (pad_oe == 32'h0));

  p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[5:2] == 4'h6) |=> ((msk_q & $past(reg_wdata & PM)) == 32'h0));

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[5:2] == 4'h7) |=>
      ((msk_q & $past(reg_wdata & PM)) == $past(reg_wdata & PM)));

  p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr[5:2] == 4'h8) |=> (($past(st_q) & ~st_q) == 32'h0));

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(st_q & ~msk_q))));

  always @(posedge clk) begin
    if (rst_n) begin
      p_upper_zero_r12: assert ((reg_rdata & ~PM) == 32'h0);
    end
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .pad_oe(pad_oe), .irq(irq), .msk_q(msk_q), .st_q(st_q)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/100ps
module test_gpio_irq_ctrl;
  localparam int NP = 24;
  localparam logic [31:0] PM = 32'h00FF_FFFF;
  localparam logic [5:0] A_BYP = 6'h00, A_DIR = 6'h04, A_OE = 6'h08, A_OUT = 6'h0C,
    A_IN = 6'h10, A_MSK = 6'h14, A_UNM = 6'h18, A_MSET = 6'h1C, A_ST = 6'h20,
    A_TYP = 6'h24, A_POL = 6'h28, A_BOTH = 6'h2C;

  // {pin[4:0], type, polarity, both, start level, next level, expected status}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {5'd1,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd2,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd3,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd4,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd5,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd6,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd7,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {5'd12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, pad_in = '0;
  logic [31:0] reg_rdata, pad_out, pad_oe, alt_sel;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] sh_typ = '0, sh_pol = '0, sh_both = '0, rv;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic make_rise(input int pin);
    @(negedge clk);
    pad_in[pin] = 1'b0;
    idle(4);
    @(negedge clk);
    pad_in[pin] = 1'b1;
    idle(5);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(A_DIR, rv); chk("R1 direction", rv, PM);
    rd(A_MSK, rv); chk("R1 mask", rv, PM);
    rd(A_ST, rv);  chk("R1 status", rv, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);

    // R7 R8 table of sense cases
    for (int v = 0; v < NV; v++) begin
      int pin;
      logic typ, pol, both, l0, l1, ex;
      {pin[4:0], typ, pol, both, l0, l1, ex} = VEC[v];
      pin[31:5] = '0;
      @(negedge clk);
      pad_in[pin] = l0;
      sh_typ[pin] = typ; sh_pol[pin] = pol; sh_both[pin] = both;
      wr(A_TYP, sh_typ); wr(A_POL, sh_pol); wr(A_BOTH, sh_both);
      idle(5);
      rd(A_ST, rv);
      idle(5);
      rd(A_ST, rv);
      @(negedge clk);
      pad_in[pin] = l1;
      idle(5);
      rd(A_ST, rv);
      chk(typ ? "R7 level sense" : "R8 edge sense", {31'h0, rv[pin]}, {31'h0, ex});
    end

    // R7 persistent level (pin 1 high, level-high): set again after each read
    rd(A_ST, rv);
    rd(A_ST, rv); chk("R7 level persists", {31'h0, rv[1]}, 32'h1);

    // R4 input synchronizer
    rd(A_IN, rv); chk("R4 input word", rv, pad_in & PM);

    // R9 clear on read, pin 13 rising edge
    sh_typ[13] = 1'b0; sh_pol[13] = 1'b1; sh_both[13] = 1'b0;
    wr(A_TYP, sh_typ); wr(A_POL, sh_pol); wr(A_BOTH, sh_both);
    make_rise(13);
    rd(A_ST, rv); rd(A_ST, rv);
    make_rise(13);
    rd(A_ST, rv); chk("R9 latched", {31'h0, rv[13]}, 32'h1);
    rd(A_ST, rv); chk("R9 cleared", {31'h0, rv[13]}, 32'h0);

    // R10 edge detected on the clearing read cycle
    @(negedge clk); pad_in[13] = 1'b0;
    idle(5);
    rd(A_ST, rv);
    @(negedge clk); pad_in[13] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd(A_ST, rv); chk("R10 not yet latched", {31'h0, rv[13]}, 32'h0);
    rd(A_ST, rv); chk("R10 kept", {31'h0, rv[13]}, 32'h1);
    rd(A_ST, rv); chk("R10 then cleared", {31'h0, rv[13]}, 32'h0);

    // R5 R6 R11 mask and combined line
    make_rise(13);
    chk("R11 masked", {31'h0, irq}, 32'h0);
    wr(A_UNM, 32'h0000_2000);
    rd(A_MSK, rv); chk("R5 unmask", rv, PM & ~32'h0000_2000);
    chk("R11 raised", {31'h0, irq}, 32'h1);
    rd(A_ST, rv);
    idle(1);
    chk("R11 dropped after read", {31'h0, irq}, 32'h0);
    make_rise(13);
    chk("R11 raised again", {31'h0, irq}, 32'h1);
    wr(A_MSET, 32'h0000_2000);
    idle(1);
    chk("R11 masked again", {31'h0, irq}, 32'h0);
    rd(A_MSK, rv); chk("R6 mask set", rv, PM);
    wr(A_UNM, 32'h0000_0005); wr(A_MSET, 32'h0000_0001);
    rd(A_MSK, rv); chk("R6 zero bits unchanged", rv, PM & ~32'h4);

    // R2 R3 output path
    wr(A_DIR, PM & ~32'h0010_0000);
    wr(A_OE, 32'h0010_0000);
    wr(A_OUT, 32'h0010_0000);
    chk("R2 driven", pad_oe, 32'h0010_0000);
    chk("R2 level", pad_out, 32'h0010_0000);
    wr(A_BYP, 32'h0010_0000);
    chk("R3 bypass undriven", pad_oe, 32'h0);
    chk("R3 alt_sel", alt_sel, 32'h0010_0000);
    wr(A_BYP, 32'h0);
    wr(A_DIR, PM);
    chk("R2 input undriven", pad_oe, 32'h0);

    // R12 pins beyond NPINS
    wr(A_OUT, 32'hFFFF_FFFF);
    rd(A_OUT, rv); chk("R12 upper bits", rv, PM);
    chk("R12 pad_out upper", pad_out, PM);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule